// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block sits between a CPU and the program flash, and it sequences the operations that software uses to reprogram its own flash. Software writes a command pattern into an 8-bit control register. It then has a short arming window in which to raise a "store" strobe. The strobe comes with a Z-style address, split into a page field and a word field, and with a 16-bit data word. A load command puts the data word into a word-addressed temporary page buffer. An erase command clears one flash page. A write command copies the whole buffer into one flash page.

Erase and write go to a flash array model through a request/acknowledge handshake, and the model chooses the operation latency. The flash is split at a page boundary, which is a parameter. Pages below the boundary form the rewrite section. An operation on the rewrite section sets a sticky busy flag that blocks reads of that section, and the flag stays set until software re-enables the section. An operation on any other page requests a CPU halt for its whole duration. A level interrupt is held for as long as the interrupt enable is set and the command-enable bit is clear.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: A command runs only if `store_stb` is sampled in one of the 4 clock cycles after the cycle that wrote the control register. A strobe that arrives later, or a strobe after an unrecognised pattern, has no effect, and the enable bit (`csr_rdata[0]`) is clear once the window has closed.
- R2: The pattern `x0000011` followed by an armed strobe raises `fl_req` with `fl_erase`=1 and `fl_page` = `z_addr[6:3]`. The request is held until `fl_ack`. The data word and `z_addr[2:0]` do not matter.
- R3: The exact pattern `00000001` followed by an armed strobe stores `wdata` in buffer word `z_addr[2:0]`, and it clears the enable bit.
- R4: The pattern `x0000101` followed by an armed strobe raises `fl_req` with `fl_erase`=0 and `fl_page` = `z_addr[6:3]`. While the request is raised, `fl_data[16*i+15:16*i]` presents buffer word i.
- R5: Once a buffer word has been loaded, a further load to that word leaves its value unchanged until the buffer is next cleared.
- R6: The buffer reads as 0xFFFF in every word after reset, after the acknowledge of a write, and after a re-enable write (pattern `x0010001`). A cleared word can be loaded again.
- R7: A pulse on `ee_write` discards every word already loaded into the buffer.
- R8: An erase or write to a page below `RWW_PAGES` sets `rww_busy` (mirrored on `csr_rdata[6]`) from the cycle after the strobe. The flag stays set after completion until a re-enable write.
- R9: An erase or write to a page at or above `RWW_PAGES` holds `cpu_halt` high for the whole request. An operation on a lower page leaves `cpu_halt` low.
- R10: Completion clears the enable bit. `irq` equals the interrupt enable (`csr_rdata[7]`, taken from `csr_wdata[7]` on each accepted write) AND NOT the enable bit.
- R11: Control register writes made while a flash request is outstanding have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write value |
| csr_rdata | output | 8 | Status: bit7 irq enable, bit6 rewrite busy, bit0 enable |
| store_stb | input | 1 | Store-program-memory strobe |
| z_addr | input | 7 | Address: page field [6:3], word field [2:0] |
| wdata | input | 16 | Data word for buffer loads |
| ee_write | input | 1 | EEPROM write pulse |
| fl_req | output | 1 | Flash operation request |
| fl_erase | output | 1 | 1 = erase, 0 = write |
| fl_page | output | 4 | Target page |
| fl_data | output | 128 | Temporary buffer contents, word 0 in the low bits |
| fl_ack | input | 1 | Flash operation complete (one-cycle pulse) |
| rww_busy | output | 1 | Rewrite section busy, reads blocked |
| cpu_halt | output | 1 | CPU halt request |
| irq | output | 1 | Completion interrupt, level |

## Verification
If the arming counter holds a wrong value, the error shows up in the first strobe cycle after a control write: either a flash request appears that should not, or a buffer word changes when it should not. Both are visible on `fl_req` or `fl_data` one cycle later. A lost valid bit or a missed buffer clear shows on `fl_data` on the cycle after the load, the acknowledge or the `ee_write` that caused it. A wrong busy or halt decision shows on `rww_busy` or `cpu_halt` in the first cycle of the request. The bench compares every output against its model on every clock, so each of these faults is reported within one or two cycles.

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl #(
  parameter int PAGES      = 16,
  parameter int PAGE_WORDS = 8,
  parameter int RWW_PAGES  = 12,
  parameter int WINDOW     = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        csr_we,
  input  logic [7:0]                                  csr_wdata,
  output logic [7:0]                                  csr_rdata,
  input  logic                                        store_stb,
  input  logic [$clog2(PAGES)+$clog2(PAGE_WORDS)-1:0] z_addr,
  input  logic [15:0]                                 wdata,
  input  logic                                        ee_write,
  output logic                                        fl_req,
  output logic                                        fl_erase,
  output logic [$clog2(PAGES)-1:0]                    fl_page,
  output logic [16*PAGE_WORDS-1:0]                    fl_data,
  input  logic                                        fl_ack,
  output logic                                        rww_busy,
  output logic                                        cpu_halt,
  output logic                                        irq
);
  localparam int PW = $clog2(PAGES);
  localparam int WW = $clog2(PAGE_WORDS);
  localparam int ZW = PW + WW;
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [PW-1:0] BOUND = PW'(RWW_PAGES);

  typedef enum logic [1:0] {C_NONE, C_LOAD, C_ERASE, C_WRITE} cmd_t;

  cmd_t          cmd;
  logic [CW-1:0] win;
  logic          en, ie, busy, op_act, op_erase, op_rww;
  logic [PW-1:0] op_page;
  logic [PAGE_WORDS-1:0] valid;

  wire [PW-1:0] z_page = z_addr[ZW-1:WW];
  wire [WW-1:0] z_word = z_addr[WW-1:0];

  wire is_load  = csr_wdata == 8'h01;
  wire is_erase = csr_wdata[6:0] == 7'h03;
  wire is_write = csr_wdata[6:0] == 7'h05;
  wire is_rwwre = csr_wdata[6:0] == 7'h11;
  wire is_cmd   = is_load | is_erase | is_write;

  wire cw      = csr_we & ~op_act;
  wire armed   = ~cw & (win != '0);
  wire fire    = armed & store_stb;
  wire ld_fire = fire & (cmd == C_LOAD);
  wire done    = op_act & fl_ack;
  wire clr_buf = ee_write | (cw & is_rwwre) | (done & ~op_erase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd      <= C_NONE;
      win      <= '0;
      en       <= 1'b0;
      ie       <= 1'b0;
      busy     <= 1'b0;
      op_act   <= 1'b0;
      op_erase <= 1'b0;
      op_rww   <= 1'b0;
      op_page  <= '0;
    end else begin
      if (cw) begin
        ie  <= csr_wdata[7];
        en  <= is_cmd;
        win <= is_cmd ? CW'(WINDOW) : '0;
        cmd <= is_load ? C_LOAD : is_erase ? C_ERASE : is_write ? C_WRITE : C_NONE;
        if (is_rwwre) busy <= 1'b0;
      end else if (armed) begin
        if (store_stb) begin
          win <= '0;
          if (cmd == C_LOAD) begin
            en <= 1'b0;
          end else begin
            op_act   <= 1'b1;
            op_erase <= (cmd == C_ERASE);
            op_page  <= z_page;
            op_rww   <= z_page < BOUND;
            if (z_page < BOUND) busy <= 1'b1;
          end
        end else begin
          win <= win - 1'b1;
          if (win == CW'(1)) en <= 1'b0;
        end
      end
      if (done) begin
        op_act <= 1'b0;
        en     <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_word
    logic [15:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr_buf) begin
        word_q   <= 16'hFFFF;
        valid[i] <= 1'b0;
      end else if (ld_fire && z_word == WW'(i) && !valid[i]) begin
        word_q   <= wdata;
        valid[i] <= 1'b1;
      end
    end
    assign fl_data[16*i +: 16] = word_q;
  end

  assign csr_rdata = {ie, busy, 5'b0, en};
  assign fl_req    = op_act;
  assign fl_erase  = op_erase;
  assign fl_page   = op_page;
  assign rww_busy  = busy;
  assign cpu_halt  = op_act & ~op_rww;
  assign irq       = ie & ~en;
endmodule

// File: rtl/flash_selfprog_ctrl_chk.sv
module flash_selfprog_ctrl_chk #(
  parameter int PAGES      = 16,
  parameter int PAGE_WORDS = 8,
  parameter int RWW_PAGES  = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     csr_we,
  input logic                     store_stb,
  input logic                     fl_req,
  input logic                     fl_ack,
  input logic                     fl_erase,
  input logic [$clog2(PAGES)-1:0] fl_page,
  input logic [16*PAGE_WORDS-1:0] fl_data,
  input logic                     rww_busy,
  input logic                     cpu_halt,
  input logic                     irq,
  input logic                     ie_bit,
  input logic                     en_bit
);
  localparam logic [$clog2(PAGES)-1:0] BOUND = $clog2(PAGES)'(RWW_PAGES);

  a_r1_start_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> $past(store_stb));

  a_r2_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_page) && $stable(fl_erase)));

  a_r6_clear_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_ack && !fl_erase) |=> (&fl_data));

  a_r8_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rww_busy && !csr_we) |=> rww_busy);

  a_r9_halt_only_upper: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (fl_req && fl_page >= BOUND));

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_bit && !en_bit));
endmodule

bind flash_selfprog_ctrl flash_selfprog_ctrl_chk #(
  .PAGES(PAGES), .PAGE_WORDS(PAGE_WORDS), .RWW_PAGES(RWW_PAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .store_stb(store_stb),
  .fl_req(fl_req), .fl_ack(fl_ack), .fl_erase(fl_erase), .fl_page(fl_page),
  .fl_data(fl_data), .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq),
  .ie_bit(csr_rdata[7]), .en_bit(csr_rdata[0])
);

// File: tb/test_flash_selfprog_ctrl.sv
module test_flash_selfprog_ctrl;
  localparam int CLK_NS = 10;
  localparam int LAT    = 5;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         csr_we = 1'b0, store_stb = 1'b0, ee_write = 1'b0, fl_ack = 1'b0;
  logic [7:0]   csr_wdata = '0, csr_rdata;
  logic [6:0]   z_addr = '0;
  logic [15:0]  wdata = '0;
  logic         fl_req, fl_erase, rww_busy, cpu_halt, irq;
  logic [3:0]   fl_page;
  logic [127:0] fl_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  flash_selfprog_ctrl i_flash_selfprog_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .store_stb(store_stb), .z_addr(z_addr),
    .wdata(wdata), .ee_write(ee_write), .fl_req(fl_req), .fl_erase(fl_erase),
    .fl_page(fl_page), .fl_data(fl_data), .fl_ack(fl_ack),
    .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] word(input int i);
    return fl_data[16*i +: 16];
  endfunction

  // reference model
  int        m_win, m_cmd, m_pg;
  bit        m_en, m_ie, m_busy, m_act, m_er, m_rwwop;
  bit [15:0] m_buf [8];
  bit        m_val [8];

  always @(posedge clk) begin
    bit act0, clr;
    int pg, wd;
    act0 = m_act; clr = 0;
    pg = int'(z_addr) / 8; wd = int'(z_addr) % 8;
    if (!rst_n) begin
      m_win = 0; m_cmd = 0; m_pg = 0; m_en = 0; m_ie = 0; m_busy = 0;
      m_act = 0; m_er = 0; m_rwwop = 0; clr = 1;
    end else begin
      if (csr_we && !act0) begin
        m_ie = csr_wdata[7]; m_win = 0; m_en = 0; m_cmd = 0;
        if (csr_wdata == 8'h01) m_cmd = 1;
        else if (csr_wdata[6:0] == 7'h03) m_cmd = 2;
        else if (csr_wdata[6:0] == 7'h05) m_cmd = 3;
        else if (csr_wdata[6:0] == 7'h11) begin m_busy = 0; clr = 1; end
        if (m_cmd != 0) begin m_en = 1; m_win = 4; end
      end else if (m_win > 0) begin
        if (store_stb) begin
          m_win = 0;
          if (m_cmd == 1) begin
            m_en = 0;
            if (!m_val[wd]) begin m_buf[wd] = wdata; m_val[wd] = 1; end
          end else begin
            m_act = 1; m_er = (m_cmd == 2); m_pg = pg; m_rwwop = pg < 12;
            if (pg < 12) m_busy = 1;
          end
        end else begin
          m_win--;
          if (m_win == 0) m_en = 0;
        end
      end
      if (act0 && fl_ack) begin m_act = 0; m_en = 0; if (!m_er) clr = 1; end
      if (ee_write) clr = 1;
    end
    if (clr) for (int i = 0; i < 8; i++) begin m_buf[i] = 16'hFFFF; m_val[i] = 0; end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R10 csr_rdata", 32'(csr_rdata), 32'({m_ie, m_busy, 5'b0, m_en}));
    chk("R1 fl_req", 32'(fl_req), 32'(m_act));
    if (m_act) begin
      chk("R2 fl_erase", 32'(fl_erase), 32'(m_er));
      chk("R2 fl_page", 32'(fl_page), 32'(m_pg));
    end
    chk("R8 rww_busy", 32'(rww_busy), 32'(m_busy));
    chk("R9 cpu_halt", 32'(cpu_halt), 32'(m_act && !m_rwwop));
    chk("R10 irq", 32'(irq), 32'(m_ie && !m_en));
    for (int i = 0; i < 8; i++) chk("R4 buffer word", 32'(word(i)), 32'(m_buf[i]));
  end

  // flash array stub
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      if (fl_ack) fl_ack = 1'b0;
      else if (fl_req) begin
        lat++;
        if (lat == LAT) begin fl_ack = 1'b1; lat = 0; end
      end
    end
  end

  task automatic wr(input logic [7:0] v);
    csr_we = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic stb(input int page, input int wd, input logic [15:0] d, input int gap);
    repeat (gap) @(negedge clk);
    store_stb = 1'b1; z_addr = 7'(page * 8 + wd); wdata = d;
    @(negedge clk);
    store_stb = 1'b0;
  endtask

  task automatic wait_done();
    while (fl_req) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R6 reset csr", 32'(csr_rdata), 32'h0);
    chk("R6 reset buffer", 32'(&fl_data), 32'h1);
    chk("R10 reset irq", 32'(irq), 32'h0);

    wr(8'h01); stb(9, 2, 16'h1234, 0);
    chk("R3 load word2", 32'(word(2)), 32'h1234);
    chk("R3 enable cleared", 32'(csr_rdata[0]), 32'h0);
    wr(8'h01); stb(0, 2, 16'hBEEF, 1);
    chk("R5 duplicate load", 32'(word(2)), 32'h1234);
    wr(8'h01); stb(0, 5, 16'h5A5A, 3);
    chk("R1 last window cycle", 32'(word(5)), 32'h5A5A);

    wr(8'h01); stb(0, 6, 16'h7777, 4);
    chk("R1 late strobe", 32'(word(6)), 32'hFFFF);
    chk("R1 enable after expiry", 32'(csr_rdata[0]), 32'h0);
    wr(8'h09); stb(0, 7, 16'h1111, 0);
    chk("R1 bad pattern", 32'(word(7)), 32'hFFFF);
    chk("R1 bad pattern no req", 32'(fl_req), 32'h0);

    wr(8'h05); stb(3, 0, 16'hDEAD, 0);
    chk("R4 write req", 32'({fl_req, fl_erase, fl_page}), 32'({1'b1, 1'b0, 4'd3}));
    chk("R4 data word2", 32'(word(2)), 32'h1234);
    chk("R8 busy set", 32'(rww_busy), 32'h1);
    chk("R9 no halt lower", 32'(cpu_halt), 32'h0);
    wait_done();
    chk("R6 cleared after write", 32'(&fl_data), 32'h1);
    chk("R8 busy persists", 32'(rww_busy), 32'h1);
    repeat (3) @(negedge clk);
    chk("R8 busy still", 32'(csr_rdata[6]), 32'h1);

    wr(8'h80);
    chk("R10 irq raised", 32'(irq), 32'h1);
    wr(8'h83); stb(14, 5, 16'h0, 0);
    chk("R2 erase req", 32'({fl_req, fl_erase, fl_page}), 32'({1'b1, 1'b1, 4'd14}));
    chk("R9 halt upper", 32'(cpu_halt), 32'h1);
    chk("R10 irq low while enabled", 32'(irq), 32'h0);
    wr(8'h00);
    chk("R11 write ignored in op", 32'(csr_rdata[7]), 32'h1);
    chk("R9 halt held", 32'(cpu_halt), 32'h1);
    wait_done();
    chk("R10 irq on completion", 32'(irq), 32'h1);
    chk("R9 halt released", 32'(cpu_halt), 32'h0);

    wr(8'h01); stb(0, 1, 16'h4321, 0);
    chk("R3 load word1", 32'(word(1)), 32'h4321);
    ee_write = 1'b1; @(negedge clk); ee_write = 1'b0;
    chk("R7 eeprom discards", 32'(word(1)), 32'hFFFF);

    wr(8'h01); stb(0, 0, 16'hAAAA, 2);
    chk("R3 load word0", 32'(word(0)), 32'hAAAA);
    wr(8'h91);
    chk("R6 re-enable clears", 32'(&fl_data), 32'h1);
    chk("R8 busy released", 32'(rww_busy), 32'h0);
    wr(8'h01); stb(0, 0, 16'h9999, 0);
    chk("R6 reload after clear", 32'(word(0)), 32'h9999);

    repeat (3) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule